// File: doc/BRIEF.md
# Indirect Buffer Access Port with Auto-Increment

This block gives a host bus access to a 64-entry internal buffer through two registers. One is a pointer register and the other is a data window. The buffer is divided by the top two pointer bits into four regions:

- outgoing data (0x00–0x0F)
- incoming data (0x10–0x1F)
- command bytes (0x20–0x2F)
- an unused range (0x30–0x3F)

Every host access to the data window acts on the entry the pointer selects, and then the pointer advances by one. A host can therefore load or drain a whole region with one pointer write followed by a burst of window accesses.

A second, untimed port serves a serial transfer engine. The engine reads outgoing words and command bytes by a 4-bit index and writes incoming words by a separate 4-bit index. The engine port has no write path into the command region.

Host requests are single-cycle pulses. Each pulse carries:

- a select: 0 for the pointer register, 1 for the data window
- a read/write flag

Every access except a window read is acknowledged in the same cycle. A window read moves the control state machine from `IDLE` to `RD_ACK`. The acknowledge and the data appear in the next cycle, and the machine then returns to `IDLE` unconditionally. The two transitions are IDLE→RD_ACK on a window read and RD_ACK→IDLE always.

Top module: `ramwin_port`

## Requirements
- R1: After reset the pointer is 0x00, the acknowledge is low, the read bus is 0x0000 and every buffer entry reads as zero.
- R2: A pointer write stores bits 5..0 of the write data and discards bits 15..6. A pointer read returns the pointer zero-extended to 16 bits. Both are acknowledged in the request cycle.
- R3: A window write stores the data at the selected entry, is acknowledged in the request cycle, and increments the pointer by one.
- R4: A window read gives no acknowledge in the request cycle. In the next cycle it gives the acknowledge with the selected entry on the read bus, and the pointer has incremented by one.
- R5: The pointer wraps from 0x3F to 0x00 when it increments.
- R6: Pointer values 0x00–0x0F reach outgoing entries 0–15, which the engine reads on its outgoing-data output. Values 0x10–0x1F reach incoming entries 0–15.
- R7: Pointer values 0x20–0x2F reach 8-bit command entries. A window write keeps only bits 15..8. A window read returns the byte in bits 15..8 with bits 7..0 zero. The engine reads the byte on its command output and cannot change it.
- R8: For pointer values 0x30–0x3F, window writes are discarded and window reads return 0x0000. The pointer still increments in both cases.
- R9: An engine write stores into the incoming entry at its write index. When the engine and a host window write hit the same incoming entry in the same cycle, the engine data is kept.
- R10: A host request that arrives during the `RD_ACK` cycle is ignored. It gives no extra acknowledge and does not change the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hreq | input | 1 | Host request pulse |
| hsel | input | 1 | 0 = pointer register, 1 = data window |
| hwr | input | 1 | 1 = write, 0 = read |
| hwdata | input | 16 | Host write data |
| hrdata | output | 16 | Host read data, valid with hack |
| hack | output | 1 | Host acknowledge |
| eng_rd_idx | input | 4 | Engine read index into outgoing and command entries |
| eng_tx_data | output | 16 | Outgoing entry at eng_rd_idx |
| eng_cmd_data | output | 8 | Command entry at eng_rd_idx |
| eng_wr_en | input | 1 | Engine write strobe for incoming entries |
| eng_wr_idx | input | 4 | Engine write index |
| eng_wr_data | input | 16 | Engine write data |

## Verification
The bench drives the window with several access patterns:

- **Burst writes then a pointer reload and burst reads.** These show whether the post-increment happens on both writes and reads.
- **Accesses that straddle each region.** Writing 0x5A77 into a command entry and reading back 0x5A00 separates byte-lane masking from full-word storage.
- **An all-ones write to the unused range that must read back zero.** This shows that discarded writes still advance the pointer.
- **A read at 0x3F.** This separates wrap-around from saturation.

Further directed cases cover ordering and isolation:

- A same-cycle host/engine write to one incoming entry checks which write wins.
- A request placed in the `RD_ACK` cycle checks that it is dropped rather than queued.
- Engine-port reads check that host writes land in the region the engine sees.

// File: rtl/ramwin_pkg.sv
package ramwin_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_RD_ACK = 1'b1
    } host_state_e;

    typedef enum logic [1:0] {
        RG_TX  = 2'd0,
        RG_RX  = 2'd1,
        RG_CMD = 2'd2,
        RG_RSV = 2'd3
    } region_e;

    function automatic region_e region_of(input logic [1:0] upper);
        return region_e'(upper);
    endfunction

endpackage

// File: rtl/ramwin_ctrl.sv
module ramwin_ctrl
    import ramwin_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hreq,
    input  logic              hsel,
    input  logic              hwr,
    input  logic [REG_W-1:0]  hwdata,
    output logic              hack,
    output logic [REG_W-1:0]  hrdata,
    output logic              st_wr_en,
    output logic [ADDR_W-1:0] st_addr,
    output logic [REG_W-1:0]  st_wdata,
    input  logic [REG_W-1:0]  st_rdata,
    output logic              busy,
    output logic [ADDR_W-1:0] addr_q
);

    host_state_e       state_q, state_d;
    logic [ADDR_W-1:0] addr_d;
    logic [REG_W-1:0]  hold_q, hold_d;
    logic              win_rd;

    assign win_rd = hreq && hsel && !hwr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // pointer and read holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            hold_q <= '0;
        end else begin
            addr_q <= addr_d;
            hold_q <= hold_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (win_rd) state_d = ST_RD_ACK;
            ST_RD_ACK: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_comb begin
        hack     = 1'b0;
        hrdata   = '0;
        st_wr_en = 1'b0;
        addr_d   = addr_q;
        hold_d   = hold_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hreq) begin
                    hack = !win_rd;
                    if (!hsel) begin
                        if (hwr) addr_d = hwdata[ADDR_W-1:0];
                        else     hrdata = REG_W'(addr_q);
                    end else begin
                        addr_d = addr_q + ADDR_W'(1);
                        if (hwr) st_wr_en = 1'b1;
                        else     hold_d   = st_rdata;
                    end
                end
            end
            ST_RD_ACK: begin
                hack   = 1'b1;
                hrdata = hold_q;
            end
            default: ;
        endcase
    end

    assign st_addr  = addr_q;
    assign st_wdata = hwdata;
    assign busy     = (state_q == ST_RD_ACK);

endmodule

// File: rtl/ramwin_store.sv
module ramwin_store
    import ramwin_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 16,
    parameter int CMD_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               h_wr_en,
    input  logic [IDX_W+1:0]   h_addr,
    input  logic [DATA_W-1:0]  h_wdata,
    output logic [DATA_W-1:0]  h_rdata,
    input  logic [IDX_W-1:0]   eng_rd_idx,
    output logic [DATA_W-1:0]  eng_tx_data,
    output logic [CMD_W-1:0]   eng_cmd_data,
    input  logic               eng_wr_en,
    input  logic [IDX_W-1:0]   eng_wr_idx,
    input  logic [DATA_W-1:0]  eng_wr_data
);

    localparam int DEPTH = 1 << IDX_W;
    localparam int PAD_W = DATA_W - CMD_W;

    logic [DATA_W-1:0] tx_mem  [DEPTH];
    logic [DATA_W-1:0] rx_mem  [DEPTH];
    logic [CMD_W-1:0]  cmd_mem [DEPTH];

    region_e           h_region;
    logic [IDX_W-1:0]  h_idx;

    assign h_region = region_of(h_addr[IDX_W+1:IDX_W]);
    assign h_idx    = h_addr[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tx_mem[i] <= '0;
        end else if (h_wr_en && h_region == RG_TX) begin
            tx_mem[h_idx] <= h_wdata;
        end
    end

    // engine write is applied last so it wins a same-entry collision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) rx_mem[i] <= '0;
        end else begin
            if (h_wr_en && h_region == RG_RX) rx_mem[h_idx] <= h_wdata;
            if (eng_wr_en)                    rx_mem[eng_wr_idx] <= eng_wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cmd_mem[i] <= '0;
        end else if (h_wr_en && h_region == RG_CMD) begin
            cmd_mem[h_idx] <= h_wdata[DATA_W-1 -: CMD_W];
        end
    end

    always_comb begin
        unique case (h_region)
            RG_TX:   h_rdata = tx_mem[h_idx];
            RG_RX:   h_rdata = rx_mem[h_idx];
            RG_CMD:  h_rdata = {cmd_mem[h_idx], {PAD_W{1'b0}}};
            default: h_rdata = '0;
        endcase
    end

    assign eng_tx_data  = tx_mem[eng_rd_idx];
    assign eng_cmd_data = cmd_mem[eng_rd_idx];

endmodule

// File: rtl/ramwin_port.sv
module ramwin_port
    import ramwin_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 16,
    parameter int CMD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hreq,
    input  logic              hsel,
    input  logic              hwr,
    input  logic [DATA_W-1:0] hwdata,
    output logic [DATA_W-1:0] hrdata,
    output logic              hack,
    input  logic [IDX_W-1:0]  eng_rd_idx,
    output logic [DATA_W-1:0] eng_tx_data,
    output logic [CMD_W-1:0]  eng_cmd_data,
    input  logic              eng_wr_en,
    input  logic [IDX_W-1:0]  eng_wr_idx,
    input  logic [DATA_W-1:0] eng_wr_data
);

    localparam int ADDR_W = IDX_W + 2;

    logic              st_wr_en;
    logic [ADDR_W-1:0] st_addr;
    logic [DATA_W-1:0] st_wdata;
    logic [DATA_W-1:0] st_rdata;
    logic              busy;
    logic [ADDR_W-1:0] addr_q;

    ramwin_ctrl #(
        .ADDR_W (ADDR_W),
        .REG_W  (DATA_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hreq     (hreq),
        .hsel     (hsel),
        .hwr      (hwr),
        .hwdata   (hwdata),
        .hack     (hack),
        .hrdata   (hrdata),
        .st_wr_en (st_wr_en),
        .st_addr  (st_addr),
        .st_wdata (st_wdata),
        .st_rdata (st_rdata),
        .busy     (busy),
        .addr_q   (addr_q)
    );

    ramwin_store #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W),
        .CMD_W  (CMD_W)
    ) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .h_wr_en      (st_wr_en),
        .h_addr       (st_addr),
        .h_wdata      (st_wdata),
        .h_rdata      (st_rdata),
        .eng_rd_idx   (eng_rd_idx),
        .eng_tx_data  (eng_tx_data),
        .eng_cmd_data (eng_cmd_data),
        .eng_wr_en    (eng_wr_en),
        .eng_wr_idx   (eng_wr_idx),
        .eng_wr_data  (eng_wr_data)
    );

endmodule

// File: rtl/ramwin_chk.sv
module ramwin_chk #(
    parameter int ADDR_W = 6,
    parameter int REG_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hreq,
    input logic              hsel,
    input logic              hwr,
    input logic [REG_W-1:0]  hwdata,
    input logic              hack,
    input logic [REG_W-1:0]  hrdata,
    input logic              busy,
    input logic [ADDR_W-1:0] addr_q
);

    logic idle_req;
    assign idle_req = !busy && hreq;

    a_r1_ack_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        hack |-> (hreq || busy));

    a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req && !hsel && hwr) |=> (addr_q == $past(hwdata[ADDR_W-1:0])));

    a_r3_write_ack_now: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req && hsel && hwr) |-> hack);

    a_r3_window_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req && hsel) |=> (addr_q == ADDR_W'($past(addr_q) + ADDR_W'(1))));

    a_r4_read_ack_later: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req && hsel && !hwr) |-> (!hack ##1 hack));

    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req && hsel && (&addr_q)) |=> (addr_q == '0));

    a_r8_unused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req && hsel && !hwr && (&addr_q[ADDR_W-1:ADDR_W-2])) |=> (hrdata == '0));

    a_r10_wait_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(addr_q));

    a_r10_no_double_ack: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

endmodule

bind ramwin_port ramwin_chk #(
    .ADDR_W (ADDR_W),
    .REG_W  (DATA_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .hreq   (hreq),
    .hsel   (hsel),
    .hwr    (hwr),
    .hwdata (hwdata),
    .hack   (hack),
    .hrdata (hrdata),
    .busy   (busy),
    .addr_q (addr_q)
);

// File: tb/ramwin_port_tb.sv
module ramwin_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hreq = 1'b0;
    logic        hsel = 1'b0;
    logic        hwr = 1'b0;
    logic [15:0] hwdata = '0;
    logic [15:0] hrdata;
    logic        hack;
    logic [3:0]  eng_rd_idx = '0;
    logic [15:0] eng_tx_data;
    logic [7:0]  eng_cmd_data;
    logic        eng_wr_en = 1'b0;
    logic [3:0]  eng_wr_idx = '0;
    logic [15:0] eng_wr_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ramwin_port u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hreq         (hreq),
        .hsel         (hsel),
        .hwr          (hwr),
        .hwdata       (hwdata),
        .hrdata       (hrdata),
        .hack         (hack),
        .eng_rd_idx   (eng_rd_idx),
        .eng_tx_data  (eng_tx_data),
        .eng_cmd_data (eng_cmd_data),
        .eng_wr_en    (eng_wr_en),
        .eng_wr_idx   (eng_wr_idx),
        .eng_wr_data  (eng_wr_data)
    );

    localparam logic [1:0] AW = 2'd0;   // pointer write
    localparam logic [1:0] AR = 2'd1;   // pointer read, check
    localparam logic [1:0] DW = 2'd2;   // window write
    localparam logic [1:0] DR = 2'd3;   // window read, check

    localparam int NV = 29;
    // {requirement, op, write data, expected read}
    localparam logic [41:0] VEC [NV] = '{
        {8'd2, AW, 16'hFFC5, 16'h0000},   // R2 upper bits dropped
        {8'd2, AR, 16'h0000, 16'h0005},   // R2
        {8'd3, AW, 16'h0000, 16'h0000},   // R3
        {8'd3, DW, 16'h1234, 16'h0000},   // R3
        {8'd3, DW, 16'hABCD, 16'h0000},   // R3
        {8'd3, AR, 16'h0000, 16'h0002},   // R3 two increments
        {8'd4, AW, 16'h0000, 16'h0000},   // R4
        {8'd4, DR, 16'h0000, 16'h1234},   // R4
        {8'd4, DR, 16'h0000, 16'hABCD},   // R4
        {8'd4, AR, 16'h0000, 16'h0002},   // R4
        {8'd7, AW, 16'h0020, 16'h0000},   // R7
        {8'd7, DW, 16'h5A77, 16'h0000},   // R7
        {8'd7, AW, 16'h0020, 16'h0000},   // R7
        {8'd7, DR, 16'h0000, 16'h5A00},   // R7 low byte zero
        {8'd8, AW, 16'h0031, 16'h0000},   // R8
        {8'd8, DW, 16'hFFFF, 16'h0000},   // R8 discarded
        {8'd8, AW, 16'h0031, 16'h0000},   // R8
        {8'd8, DR, 16'h0000, 16'h0000},   // R8 reads zero
        {8'd8, AR, 16'h0000, 16'h0032},   // R8 still advanced
        {8'd5, AW, 16'h003F, 16'h0000},   // R5
        {8'd5, DR, 16'h0000, 16'h0000},   // R5
        {8'd5, AR, 16'h0000, 16'h0000},   // R5 wrapped
        {8'd6, AW, 16'h001F, 16'h0000},   // R6
        {8'd6, DW, 16'hBEEF, 16'h0000},   // R6 incoming entry 15
        {8'd6, AW, 16'h001F, 16'h0000},   // R6
        {8'd6, DR, 16'h0000, 16'hBEEF},   // R6
        {8'd6, AW, 16'h000F, 16'h0000},   // R6 outgoing entry 15 untouched
        {8'd6, DR, 16'h0000, 16'h0000},   // R6
        {8'd6, AR, 16'h0000, 16'h0010}    // R6
    };

    task automatic check(input int req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one host access; samples the request cycle and the following cycle
    task automatic access(input logic sel, input logic wr, input logic [15:0] wd,
                          output logic ack0, output logic [15:0] rd0,
                          output logic ack1, output logic [15:0] rd1);
        @(negedge clk);
        hreq = 1'b1; hsel = sel; hwr = wr; hwdata = wd;
        #1;
        ack0 = hack; rd0 = hrdata;
        @(posedge clk);
        @(negedge clk);
        hreq = 1'b0; hwr = 1'b0; hsel = 1'b0; hwdata = '0;
        #1;
        ack1 = hack; rd1 = hrdata;
    endtask

    task automatic run_op(input int req, input logic [1:0] op,
                          input logic [15:0] wd, input logic [15:0] exp);
        logic a0, a1;
        logic [15:0] r0, r1;
        access(op[1], (op == AW) || (op == DW), wd, a0, r0, a1, r1);
        unique case (op)
            AW, DW: check(req, "write ack", {15'd0, a0}, 16'd1);
            AR: begin
                check(req, "ptr ack", {15'd0, a0}, 16'd1);
                check(req, "ptr value", r0, exp);
            end
            DR: begin
                check(req, "read early ack", {15'd0, a0}, 16'd0);
                check(req, "read ack", {15'd0, a1}, 16'd1);
                check(req, "read data", r1, exp);
            end
            default: ;
        endcase
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic a0, a1;
        logic [15:0] r0, r1;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check(1, "reset ack", {15'd0, hack}, 16'd0);
        check(1, "reset rdata", hrdata, 16'h0000);
        check(1, "reset tx entry", eng_tx_data, 16'h0000);
        rst_n = 1'b1;
        run_op(1, AR, 16'h0, 16'h0000);   // R1 pointer zero

        for (int i = 0; i < NV; i++) begin
            run_op(int'(VEC[i][41:34]), VEC[i][33:32], VEC[i][31:16], VEC[i][15:0]);
        end

        // R6 engine sees outgoing entries written by the host
        eng_rd_idx = 4'd0; #1;
        check(6, "engine tx 0", eng_tx_data, 16'h1234);
        eng_rd_idx = 4'd1; #1;
        check(6, "engine tx 1", eng_tx_data, 16'hABCD);
        // R7 engine sees command byte
        eng_rd_idx = 4'd0; #1;
        check(7, "engine cmd 0", {8'd0, eng_cmd_data}, 16'h005A);

        // R9 engine write to incoming entry 3, host reads it
        @(negedge clk);
        eng_wr_en = 1'b1; eng_wr_idx = 4'd3; eng_wr_data = 16'h1111;
        @(negedge clk);
        eng_wr_en = 1'b0;
        run_op(9, AW, 16'h0013, 16'h0);
        run_op(9, DR, 16'h0, 16'h1111);
        // R7 command byte unchanged after engine activity
        check(7, "cmd after engine write", {8'd0, eng_cmd_data}, 16'h005A);

        // R9 collision: host and engine write incoming entry 4 together
        run_op(9, AW, 16'h0014, 16'h0);
        @(negedge clk);
        hreq = 1'b1; hsel = 1'b1; hwr = 1'b1; hwdata = 16'h2222;
        eng_wr_en = 1'b1; eng_wr_idx = 4'd4; eng_wr_data = 16'h3333;
        @(negedge clk);
        hreq = 1'b0; hsel = 1'b0; hwr = 1'b0; eng_wr_en = 1'b0;
        run_op(9, AW, 16'h0014, 16'h0);
        run_op(9, DR, 16'h0, 16'h3333);

        // R10 request during the read wait cycle is dropped
        run_op(10, AW, 16'h0000, 16'h0);
        @(negedge clk);
        hreq = 1'b1; hsel = 1'b1; hwr = 1'b0;
        @(negedge clk);
        hsel = 1'b0; hwr = 1'b1; hwdata = 16'h0010;   // arrives in RD_ACK
        #1;
        check(10, "completion ack", {15'd0, hack}, 16'd1);
        @(negedge clk);
        hreq = 1'b0; hwr = 1'b0; hwdata = '0;
        #1;
        check(10, "no extra ack", {15'd0, hack}, 16'd0);
        run_op(10, AR, 16'h0, 16'h0001);

        access(1'b1, 1'b0, 16'h0, a0, r0, a1, r1);   // R4 read at 0x01
        check(4, "second tx read", r1, 16'hABCD);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule